// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 96 level-sensitive interrupt sources into three banks of 32 and presents them to a processor on two lines, a normal interrupt request (`irq_o`) and a fast interrupt request (`fiq_o`). Each bank holds its own enable, mask and line-select registers, and an IRQ pending and a FIQ pending register that software reads to find out which sources are asking for service. Source n lives in bank n/32 at bit n%32.

Software reaches the registers over a simple 32-bit word-addressed bus with separate read and write strobes. A vector register reports the lowest-numbered source pending on the IRQ line, so a handler can dispatch without scanning the pending words. Source 0 is an external non-maskable-style input. Its IRQ pending bit is a sticky latch that is cleared by writing 1. A small control register picks how that input is recognised: by level or by edge, either polarity. A protection bit and a base-address word are held for software.

Top module: `irqc_banked`

## Requirements
- R1: Reset is synchronous and active-low. It clears every enable register and every select register. It sets every mask register to all ones, clears both pending sets, drives `irq_o` and `fiq_o` low and sets the read data to 0.
- R2: Per-bank registers decode at byte offset base + 4*b for bank b: IRQ pending 0x10, FIQ pending 0x20, select 0x30, enable 0x40, mask 0x50. Source n uses bank n/32, bit n%32. A write to select, enable or mask takes effect at that clock edge.
- R3: A source is live only while its input is 1, its enable bit is 1 and its mask bit is 0. A mask bit of 1 or an enable bit of 0 keeps it off both lines.
- R4: A live source with select bit 0 shows in IRQ pending and drives `irq_o`. With select bit 1 it shows in FIQ pending and drives `fiq_o`. Pending bits register one clock after the input or the configuration changes.
- R5: The pending bits of sources 1 to 95 follow the live state every cycle and clear without software action once the source drops.
- R6: IRQ pending bit 0 is sticky. Once set, it stays set until a write to offset 0x10 with data bit 0 equal to 1. A write of 0 to that bit leaves it set, and so does a write to FIQ pending (0x20).
- R7: The source-0 trigger mode at offset 0x0C uses bits 1:0: 0 high level, 1 rising edge, 2 falling edge, 3 low level. It reads back with all other bits 0. The reset value is 0.
- R8: The vector register at 0x00 reads 4 times the lowest-numbered source with its IRQ pending bit set. It reads 0 when no IRQ pending bit is set. FIQ pending bits do not affect it.
- R9: The protection register at 0x08 holds bit 0 only; the other bits read 0. The base register at 0x04 holds bits 31:2, and bits 1:0 read 0.
- R10: Read data is registered. It shows the addressed register one clock after the read strobe and holds its value while the strobe is low. Unmapped offsets and offsets that are not word aligned read 0.
- R11: `irq_o` is high exactly when some IRQ pending bit is set, and `fiq_o` is high exactly when some FIQ pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level interrupt inputs, bit n is source n |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that reset is held low for at least two clocks at start-up and whenever it is applied again. Only then do the one-cycle lookbacks on enable and mask see defined values. They also assume that read and write strobes are never raised in the same cycle, so a read of the vector is never disturbed by a pending-clear in that cycle. The stimulus drives every strobe on the falling edge, asserts exactly one strobe per access, and holds reset for four clocks each time.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the banked interrupt controller.
// Assumes byte addresses of 8 bits with 16-byte register groups.
package irqc_pkg;

    localparam int unsigned ADDR_W = 8;

    // Register group codes taken from address bits 7:4.
    localparam logic [3:0] GRP_CTRL  = 4'h0;
    localparam logic [3:0] GRP_IPEND = 4'h1;
    localparam logic [3:0] GRP_FPEND = 4'h2;
    localparam logic [3:0] GRP_SEL   = 4'h3;
    localparam logic [3:0] GRP_EN    = 4'h4;
    localparam logic [3:0] GRP_MASK  = 4'h5;

    // Word index inside the control group.
    localparam logic [1:0] CTL_VECTOR = 2'd0;
    localparam logic [1:0] CTL_BASE   = 2'd1;
    localparam logic [1:0] CTL_PROT   = 2'd2;
    localparam logic [1:0] CTL_NMI    = 2'd3;

    // Recognition mode of the source-0 input.
    typedef enum logic [1:0] {
        NMI_HIGH = 2'd0,
        NMI_RISE = 2'd1,
        NMI_FALL = 2'd2,
        NMI_LOW  = 2'd3
    } nmi_mode_e;

endpackage

// File: rtl/irqc_nmi_cond.sv
// Conditions the raw source-0 input according to the selected mode.
// Level modes pass the (possibly inverted) level; edge modes give a
// one-cycle pulse. Assumes the input is already synchronous to clk.
module irqc_nmi_cond
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw_i,
    input  nmi_mode_e mode_i,
    output logic      trig_o
);

    logic prev_q;

    // Remember the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw_i;
    end

    // Select the trigger condition for the current mode.
    always_comb begin
        unique case (mode_i)
            NMI_HIGH: trig_o = raw_i;
            NMI_RISE: trig_o = raw_i & ~prev_q;
            NMI_FALL: trig_o = ~raw_i & prev_q;
            NMI_LOW:  trig_o = ~raw_i;
            default:  trig_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqc_bank.sv
// One bank of the controller: select, enable and mask storage plus the
// IRQ and FIQ pending registers. Bits set in STICKY_MASK hold their IRQ
// pending state until cleared by a 1 in clr_i; all other bits follow the
// live state each cycle. Assumes write strobes are already decoded.
module irqc_bank #(
    parameter int unsigned     W           = 32,
    parameter logic [W-1:0]    STICKY_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata_i,
    input  logic         we_sel_i,
    input  logic         we_en_i,
    input  logic         we_mask_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] ipend_o,
    output logic [W-1:0] fpend_o
);

    logic [W-1:0] live;
    logic [W-1:0] ipend_next;
    logic [W-1:0] fpend_next;

    // Configuration registers, written one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o  <= '0;
            en_o   <= '0;
            mask_o <= '1;
        end else begin
            if (we_sel_i)  sel_o  <= wdata_i;
            if (we_en_i)   en_o   <= wdata_i;
            if (we_mask_i) mask_o <= wdata_i;
        end
    end

    // Gate the sources and steer them to a line; sticky bits keep state.
    always_comb begin
        live       = src_i & en_o & ~mask_o;
        ipend_next = (live & ~sel_o) | (ipend_o & STICKY_MASK & ~clr_i);
        fpend_next = live & sel_o;
    end

    // Pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipend_o <= '0;
            fpend_o <= '0;
        end else begin
            ipend_o <= ipend_next;
            fpend_o <= fpend_next;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority search: reports the lowest set index of req_i and
// whether any bit is set. Purely combinational.
module irqc_prio #(
    parameter int unsigned N     = 96,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/irqc_banked.sv
// Banked interrupt controller top: register decode, control registers,
// source-0 conditioning, the per-bank storage, priority vector and the
// two request lines. Assumes one strobe per access and at most four banks
// (the bank index is address bits 3:2).
module irqc_banked
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned BANK_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic                          bus_wr_i,
    input  logic [BANK_W-1:0]             bus_wdata_i,
    input  logic                          bus_rd_i,
    output logic [BANK_W-1:0]             bus_rdata_o,
    output logic                          irq_o,
    output logic                          fiq_o
);

    localparam int unsigned NSRC  = NUM_BANKS * BANK_W;
    localparam int unsigned IDX_W = $clog2(NSRC);
    localparam int unsigned PAD_W = BANK_W - IDX_W - 2;

    logic [3:0]        grp;
    logic [1:0]        widx;
    logic              aligned;
    logic [NSRC-1:0]   sel_all, en_all, mask_all, ipend_all, fpend_all;
    logic [NSRC-1:0]   src_c;
    logic              nmi_trig;
    logic              nmi_clr;
    logic [BANK_W-1:2] base_q;
    logic              prot_q;
    nmi_mode_e         nmi_mode_q;
    logic              vec_any;
    logic [IDX_W-1:0]  vec_idx;
    logic [BANK_W-1:0] vector;
    logic [BANK_W-1:0] rd_next;

    // Split the address into group and word index.
    always_comb begin
        grp     = bus_addr_i[7:4];
        widx    = bus_addr_i[3:2];
        aligned = (bus_addr_i[1:0] == 2'b00);
    end

    // Clear request for the sticky source-0 IRQ pending bit.
    assign nmi_clr = bus_wr_i && aligned && grp == GRP_IPEND && widx == 2'd0
                     && bus_wdata_i[0];

    // Control registers: base address, protection and source-0 mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            prot_q     <= 1'b0;
            nmi_mode_q <= NMI_HIGH;
        end else if (bus_wr_i && aligned && grp == GRP_CTRL) begin
            if (widx == CTL_BASE) base_q     <= bus_wdata_i[BANK_W-1:2];
            if (widx == CTL_PROT) prot_q     <= bus_wdata_i[0];
            if (widx == CTL_NMI)  nmi_mode_q <= nmi_mode_e'(bus_wdata_i[1:0]);
        end
    end

    irqc_nmi_cond u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (src_i[0]),
        .mode_i (nmi_mode_q),
        .trig_o (nmi_trig)
    );

    assign src_c = {src_i[NSRC-1:1], nmi_trig};

    // One storage bank per group of BANK_W sources; bank 0 bit 0 is sticky.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] STICKY = (b == 0) ? BANK_W'(1) : '0;
        logic hit;
        logic [BANK_W-1:0] clr;

        assign hit = bus_wr_i && aligned && widx == 2'(b);
        assign clr = (hit && grp == GRP_IPEND) ? bus_wdata_i : '0;

        irqc_bank #(
            .W           (BANK_W),
            .STICKY_MASK (STICKY)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wdata_i   (bus_wdata_i),
            .we_sel_i  (hit && grp == GRP_SEL),
            .we_en_i   (hit && grp == GRP_EN),
            .we_mask_i (hit && grp == GRP_MASK),
            .clr_i     (clr),
            .src_i     (src_c[b*BANK_W +: BANK_W]),
            .sel_o     (sel_all[b*BANK_W +: BANK_W]),
            .en_o      (en_all[b*BANK_W +: BANK_W]),
            .mask_o    (mask_all[b*BANK_W +: BANK_W]),
            .ipend_o   (ipend_all[b*BANK_W +: BANK_W]),
            .fpend_o   (fpend_all[b*BANK_W +: BANK_W])
        );
    end

    irqc_prio #(
        .N     (NSRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i (ipend_all),
        .any_o (vec_any),
        .idx_o (vec_idx)
    );

    // Vector word: four times the winning source number, 0 when idle.
    assign vector = vec_any ? {{PAD_W{1'b0}}, vec_idx, 2'b00} : '0;

    // Request lines.
    assign irq_o = |ipend_all;
    assign fiq_o = |fpend_all;

    // Read multiplexer over control and per-bank registers.
    always_comb begin
        rd_next = '0;
        if (aligned) begin
            if (grp == GRP_CTRL) begin
                unique case (widx)
                    CTL_VECTOR: rd_next = vector;
                    CTL_BASE:   rd_next = {base_q, 2'b00};
                    CTL_PROT:   rd_next = {{(BANK_W-1){1'b0}}, prot_q};
                    CTL_NMI:    rd_next = {{(BANK_W-2){1'b0}}, nmi_mode_q};
                    default:    rd_next = '0;
                endcase
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (widx == 2'(b)) begin
                        unique case (grp)
                            GRP_IPEND: rd_next = ipend_all[b*BANK_W +: BANK_W];
                            GRP_FPEND: rd_next = fpend_all[b*BANK_W +: BANK_W];
                            GRP_SEL:   rd_next = sel_all[b*BANK_W +: BANK_W];
                            GRP_EN:    rd_next = en_all[b*BANK_W +: BANK_W];
                            GRP_MASK:  rd_next = mask_all[b*BANK_W +: BANK_W];
                            default:   rd_next = '0;
                        endcase
                    end
                end
            end
        end
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_next;
    end

endmodule

// File: rtl/irqc_checker.sv
// Temporal checks for irqc_banked, attached by bind below. Assumes reset
// is held for at least two clocks and strobes are not raised together.
module irqc_checker #(
    parameter int unsigned NSRC   = 96,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              bus_rd_i,
    input logic [7:0]        bus_addr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [NSRC-1:0]   ipend_all,
    input logic [NSRC-1:0]   fpend_all,
    input logic [NSRC-1:0]   en_all,
    input logic [NSRC-1:0]   mask_all,
    input logic              nmi_clr
);

    localparam logic [NSRC-1:0] NOT_BIT0 = ~NSRC'(1);

    // R1: a reset cycle leaves both request lines low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o));

    // R3: no non-sticky pending bit without enable set and mask clear.
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((ipend_all | fpend_all) & ~$past(en_all & ~mask_all) & NOT_BIT0) == '0));

    // R4: a source above 0 is never pending on both lines.
    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipend_all & fpend_all & NOT_BIT0) == '0));

    // R6: the sticky bit stays set until cleared.
    p_nmi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend_all[0] && !nmi_clr) |=> ipend_all[0]);

    // R8: the vector reads 0 when nothing is pending on IRQ.
    p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 8'h00 && ipend_all == '0) |=> (bus_rdata_o == '0));

    // R10: read data holds while no read is strobed.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

bind irqc_banked irqc_checker #(
    .NSRC   (NUM_BANKS*BANK_W),
    .DATA_W (BANK_W)
) u_irqc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .ipend_all   (ipend_all),
    .fpend_all   (fpend_all),
    .en_all      (en_all),
    .mask_all    (mask_all),
    .nmi_clr     (nmi_clr)
);

// File: tb/test_irqc_banked.sv
`timescale 1ns/1ps
module test_irqc_banked;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int total = 0;
    int fails = 0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    irqc_banked i_irqc_banked (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    // Vector fields: [11:5] source, [4] sel, [3] en, [2] mask, [1] irq, [0] fiq
    localparam logic [11:0] TBL [9] = '{
        {7'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'd37, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {7'd70, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {7'd95, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'd95, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'd32, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'd63, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {7'd1,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'd64, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        chk("R1 irq_o", {31'd0, irq}, 32'd0);
        chk("R1 fiq_o", {31'd0, fiq}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        bus_read(8'h40, got); chk("R1 enable b0", got, 32'h0);
        bus_read(8'h58, got); chk("R1 mask b2", got, 32'hFFFF_FFFF);
        bus_read(8'h34, got); chk("R1 select b1", got, 32'h0);

        // Table walk: R2 R3 R4 single-source routing
        for (int i = 0; i < 9; i++) begin
            logic [6:0]  n;
            logic [7:0]  bo;
            logic [31:0] bit1;
            n    = TBL[i][11:5];
            bo   = {4'd0, 2'(n / 32), 2'b00};
            bit1 = 32'd1 << (n % 32);
            do_reset();
            src = '0;
            bus_write(8'h30 + bo, TBL[i][4] ? bit1 : 32'h0);
            bus_write(8'h40 + bo, TBL[i][3] ? bit1 : 32'h0);
            bus_write(8'h50 + bo, TBL[i][2] ? 32'hFFFF_FFFF : ~bit1);
            src[n] = 1'b1;
            settle();
            chk($sformatf("R3/R4 irq_o src %0d", n), {31'd0, irq}, {31'd0, TBL[i][1]});
            chk($sformatf("R3/R4 fiq_o src %0d", n), {31'd0, fiq}, {31'd0, TBL[i][0]});
            bus_read(8'h10 + bo, got);
            chk($sformatf("R2 irq pend src %0d", n), got, TBL[i][1] ? bit1 : 32'h0);
            bus_read(8'h20 + bo, got);
            chk($sformatf("R2 fiq pend src %0d", n), got, TBL[i][0] ? bit1 : 32'h0);
            bus_read(8'h00, got);
            chk($sformatf("R8 vector src %0d", n), got, TBL[i][1] ? {23'd0, n, 2'b00} : 32'h0);
        end
        src = '0;

        // R8 priority and R5 follow-the-input
        do_reset();
        bus_write(8'h40, 32'h0000_0008);
        bus_write(8'h50, 32'hFFFF_FFF7);
        bus_write(8'h44, 32'hFFFF_FFFF);
        bus_write(8'h54, 32'h0);
        bus_write(8'h48, 32'hFFFF_FFFF);
        bus_write(8'h58, 32'h0);
        src[40] = 1'b1; src[70] = 1'b1;
        settle();
        bus_read(8'h00, got); chk("R8 vector 40 over 70", got, 32'd160);
        src[3] = 1'b1;
        settle();
        bus_read(8'h00, got); chk("R8 vector 3 wins", got, 32'd12);
        bus_write(8'h30, 32'h0000_0008);
        settle();
        bus_read(8'h00, got); chk("R8 FIQ source ignored by vector", got, 32'd160);
        chk("R11 fiq_o with FIQ source", {31'd0, fiq}, 32'd1);
        bus_read(8'h30, got); chk("R2 select b0 readback", got, 32'h8);
        bus_read(8'h48, got); chk("R2 enable b2 readback", got, 32'hFFFF_FFFF);
        src = '0;
        settle();
        chk("R5 irq_o drops", {31'd0, irq}, 32'd0);
        chk("R5 fiq_o drops", {31'd0, fiq}, 32'd0);
        bus_read(8'h14, got); chk("R5 pend b1 clear", got, 32'h0);

        // R6 sticky source 0 in high-level mode
        do_reset();
        bus_write(8'h40, 32'h1);
        bus_write(8'h50, 32'hFFFF_FFFE);
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk); src[0] = 1'b0;
        settle();
        chk("R6 irq_o latched", {31'd0, irq}, 32'd1);
        bus_read(8'h10, got); chk("R6 pend bit0 latched", got, 32'h1);
        bus_write(8'h10, 32'h0); settle();
        bus_read(8'h10, got); chk("R6 write 0 ignored", got, 32'h1);
        bus_write(8'h20, 32'h1); settle();
        bus_read(8'h10, got); chk("R6 FIQ pend write ignored", got, 32'h1);
        bus_write(8'h10, 32'h1); settle();
        bus_read(8'h10, got); chk("R6 write 1 clears", got, 32'h0);
        chk("R11 irq_o after clear", {31'd0, irq}, 32'd0);

        // R7 rising edge mode
        bus_write(8'h0C, 32'hFFFF_FFFD);
        bus_read(8'h0C, got); chk("R7 mode readback", got, 32'h1);
        bus_write(8'h10, 32'h1);
        @(negedge clk); src[0] = 1'b1;
        settle();
        bus_read(8'h10, got); chk("R7 rising sets", got, 32'h1);
        bus_write(8'h10, 32'h1); settle();
        bus_read(8'h10, got); chk("R7 held high no retrigger", got, 32'h0);
        // low-level mode
        bus_write(8'h0C, 32'h3); settle();
        bus_read(8'h10, got); chk("R7 low mode idle while high", got, 32'h0);
        @(negedge clk); src[0] = 1'b0;
        settle();
        bus_read(8'h10, got); chk("R7 low level sets", got, 32'h1);
        // falling edge mode
        bus_write(8'h0C, 32'h2);
        bus_write(8'h10, 32'h1);
        @(negedge clk); src[0] = 1'b1;
        settle();
        bus_read(8'h10, got); chk("R7 fall mode ignores rise", got, 32'h0);
        @(negedge clk); src[0] = 1'b0;
        settle();
        bus_read(8'h10, got); chk("R7 falling sets", got, 32'h1);

        // R9 protection and base registers
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, got); chk("R9 protection bit only", got, 32'h1);
        bus_write(8'h04, 32'h1234_5677);
        bus_read(8'h04, got); chk("R9 base aligned", got, 32'h1234_5674);

        // R10 read timing, hold and unmapped reads
        bus_read(8'h60, got); chk("R10 unmapped reads 0", got, 32'h0);
        bus_read(8'h05, got); chk("R10 unaligned reads 0", got, 32'h0);
        bus_read(8'h04, got);
        repeat (3) @(negedge clk);
        chk("R10 data holds without strobe", rdata, 32'h1234_5674);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule